// File: doc/BRIEF.md
# Lockable Microprocessor Register Block

This block sits between a host processor bus and the register state of a dual-receive-port line interface. The host reaches it through a byte-wide address and data bus. A chip select qualifies separate read and write strobes, both sampled on the rising clock edge. Configuration registers are protected by a key mechanism. Two writes of fixed values to the two key addresses open them, and two writes of another pair of values close them again. The block leaves reset closed.

Several register groups stay writable whatever the key state: the power-down control register, the alarm status and mask registers, and a bank of general maintenance registers. Each of the two receive ports owns an address window. While a port's power-down bit is set, writes into its window are dropped. Reads in that window repeat the last value read there, and the stored contents are kept for when the port wakes up.

Alarm inputs are single-cycle pulses that set sticky status bits. Software clears a status bit by writing 1 to it. The active-low interrupt output is asserted whenever a status bit is set and its mask bit does not inhibit it.

Top module: `lockreg_hub`

## Requirements
- R1: After reset the block is closed, `rdata` is 0x00, `irq_n` is 1, and every register reads 0x00 except the mask register at 0x09, which reads all ones in its NUM_ALARMS low bits (0x0F by default).
- R2: The block opens after a write of 0x00 to address 0x00 followed directly by a write of 0xFF to address 0x01. Bit 0 of address 0x00 then reads 1, and the configuration registers at 0x02 and 0x03 accept writes.
- R3: The block closes after a write of 0xDE to address 0x00 followed directly by a write of 0xAD to address 0x01. Bit 0 of address 0x00 then reads 0, and writes to 0x02 and 0x03 leave their contents unchanged.
- R4: A key sequence restarts if any other write comes between its two writes, and the key state is then unchanged. Reads between the two writes do not break the sequence.
- R5: The control register 0x04, the mask register 0x09 and the general registers 0x10 to 0x13 accept writes while the block is closed.
- R6: A pulse on `alarm_in[i]` sets bit i of the status register at 0x08. The bit stays set until a write to 0x08 with data bit i at 1. If a pulse and a clear of the same bit fall in the same cycle, the bit stays set.
- R7: `irq_n` is 0 exactly while some status bit is 1 and the matching mask bit is 0. A mask bit of 1 inhibits that source.
- R8: While bit 0 of register 0x04 is 1 (port A down), writes to addresses 0x20 to 0x45 are discarded. Reads there return the last value read in that window while port A was up, and the other port's window is not affected.
- R9: While bit 1 of register 0x04 is 1 (port B down), the same gating applies to addresses 0x60 to 0x85.
- R10: Power-down does not change stored window contents. After the power-down bit is cleared, the values written before power-down read back.
- R11: A read strobe sampled on an edge loads `rdata` at that edge. With no read strobe, `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, qualifies `rd` and `wr` |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| alarm_in | input | NUM_ALARMS | Alarm pulses, one per source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bound checker watches properties that must hold on every cycle:
- A completed open sequence leaves the block open on the next cycle.
- A closed block never changes its configuration contents.
- Status bits are set by their alarm pulses and are sticky until a status write.
- The interrupt falls only after an alarm pulse or a host write.
- `rdata` holds without a read strobe.
- Port A's window storage is frozen while port A is down.

Other behaviours depend on a run of several accesses and are shown only by the bench's scenarios:
- Sequence restart by an intervening write.
- The last-read value returned from a powered-down window.
- Contents preserved across a power-down episode.
- Set-over-clear priority in a single cycle.
- The mask-qualified interrupt level.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
   localparam logic [7:0] KEY_ADDR_FIRST  = 8'h00;
   localparam logic [7:0] KEY_ADDR_SECOND = 8'h01;
   localparam logic [7:0] OPEN_FIRST      = 8'h00;
   localparam logic [7:0] OPEN_SECOND     = 8'hFF;
   localparam logic [7:0] CLOSE_FIRST     = 8'hDE;
   localparam logic [7:0] CLOSE_SECOND    = 8'hAD;
   localparam logic [7:0] CFG_BASE        = 8'h02;
   localparam logic [7:0] CTRL_ADDR       = 8'h04;
   localparam logic [7:0] STAT_ADDR       = 8'h08;
   localparam logic [7:0] MASK_ADDR       = 8'h09;
   localparam logic [7:0] GEN_BASE        = 8'h10;
   localparam logic [7:0] WIN_A_FIRST     = 8'h20;
   localparam logic [7:0] WIN_A_LAST      = 8'h45;
   localparam logic [7:0] WIN_B_FIRST     = 8'h60;
   localparam logic [7:0] WIN_B_LAST      = 8'h85;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_OPEN_HALF,
      SEQ_CLOSE_HALF
   } seq_e;
endpackage

// File: rtl/lockreg_keyfsm.sv
module lockreg_keyfsm
   import lockreg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic       unlocked
);
   seq_e seq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= SEQ_IDLE;
         unlocked <= 1'b0;
      end else if (wr_en) begin
         seq_q <= SEQ_IDLE;
         if (addr == KEY_ADDR_FIRST) begin
            if (wdata == OPEN_FIRST)       seq_q <= SEQ_OPEN_HALF;
            else if (wdata == CLOSE_FIRST) seq_q <= SEQ_CLOSE_HALF;
         end else if (addr == KEY_ADDR_SECOND) begin
            if (seq_q == SEQ_OPEN_HALF && wdata == OPEN_SECOND)
               unlocked <= 1'b1;
            else if (seq_q == SEQ_CLOSE_HALF && wdata == CLOSE_SECOND)
               unlocked <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lockreg_irq.sv
module lockreg_irq #(
   parameter int NUM_ALARMS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_ALARMS-1:0] alarm_in,
   input  logic                  clr_en,
   input  logic                  mask_we,
   input  logic [NUM_ALARMS-1:0] wbits,
   output logic [NUM_ALARMS-1:0] status,
   output logic [NUM_ALARMS-1:0] mask,
   output logic                  irq_n
);
   logic [NUM_ALARMS-1:0] clr_bits;

   always_comb clr_bits = clr_en ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         status <= (status & ~clr_bits) | alarm_in;
         if (mask_we) mask <= wbits;
      end
   end

   always_comb irq_n = ~|(status & ~mask);
endmodule

// File: rtl/lockreg_portwin.sv
module lockreg_portwin #(
   parameter logic [7:0] FIRST = 8'h20,
   parameter logic [7:0] LAST  = 8'h45,
   parameter int         DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pdn,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   output logic             hit,
   output logic [7:0]       rdat,
   output logic [DEPTH*8-1:0] store_flat
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1 || DEPTH > (int'(LAST) - int'(FIRST) + 1)) begin : g_bad_depth
      $error("lockreg_portwin: DEPTH does not fit the window");
   end

   logic [7:0] mem [DEPTH];
   logic [7:0] last_q;
   logic [7:0] off;
   logic       in_store;
   logic [7:0] live;

   always_comb begin
      hit      = (addr >= FIRST) && (addr <= LAST);
      off      = addr - FIRST;
      in_store = hit && (int'(off) < DEPTH);
      live     = in_store ? mem[off[IW-1:0]] : 8'h00;
      rdat     = pdn ? last_q : live;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
         last_q <= 8'h00;
      end else if (!pdn) begin
         if (wr_en && in_store) mem[off[IW-1:0]] <= wdata;
         if (rd_en && hit)      last_q <= live;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign store_flat[g*8 +: 8] = mem[g];
   end
endmodule

// File: rtl/lockreg_hub.sv
module lockreg_hub
   import lockreg_pkg::*;
#(
   parameter int NUM_ALARMS = 4,
   parameter int NUM_CFG    = 2,
   parameter int NUM_GEN    = 4,
   parameter int WIN_DEPTH  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic                  wr,
   input  logic                  rd,
   input  logic [7:0]            addr,
   input  logic [7:0]            wdata,
   output logic [7:0]            rdata,
   input  logic [NUM_ALARMS-1:0] alarm_in,
   output logic                  irq_n
);
   if (NUM_ALARMS < 1 || NUM_ALARMS > 8) begin : g_bad_alarms
      $error("lockreg_hub: NUM_ALARMS must be 1..8");
   end
   if (NUM_CFG < 1 || NUM_CFG > 2) begin : g_bad_cfg
      $error("lockreg_hub: NUM_CFG must be 1..2");
   end
   if (NUM_GEN < 1 || NUM_GEN > 16) begin : g_bad_gen
      $error("lockreg_hub: NUM_GEN must be 1..16");
   end

   logic                  wr_en, rd_en, unlocked;
   logic [7:0]            cfg_q [NUM_CFG];
   logic [7:0]            gen_q [NUM_GEN];
   logic [1:0]            ctrl_q;
   logic [NUM_ALARMS-1:0] status, mask;
   logic                  hit_a, hit_b;
   logic [7:0]            rdat_a, rdat_b, rd_val;
   logic [NUM_CFG*8-1:0]  cfg_flat;
   logic [WIN_DEPTH*8-1:0] wina_store, winb_store;
   logic [7:0]            cfg_off, gen_off;

   always_comb begin
      wr_en   = cs & wr;
      rd_en   = cs & rd;
      cfg_off = addr - CFG_BASE;
      gen_off = addr - GEN_BASE;
   end

   lockreg_keyfsm key_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .unlocked(unlocked)
   );

   lockreg_irq #(.NUM_ALARMS(NUM_ALARMS)) irq_i (
      .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in),
      .clr_en(wr_en && addr == STAT_ADDR),
      .mask_we(wr_en && addr == MASK_ADDR),
      .wbits(wdata[NUM_ALARMS-1:0]),
      .status(status), .mask(mask), .irq_n(irq_n)
   );

   lockreg_portwin #(.FIRST(WIN_A_FIRST), .LAST(WIN_A_LAST), .DEPTH(WIN_DEPTH)) win_a_i (
      .clk(clk), .rst_n(rst_n), .pdn(ctrl_q[0]), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .hit(hit_a), .rdat(rdat_a), .store_flat(wina_store)
   );

   lockreg_portwin #(.FIRST(WIN_B_FIRST), .LAST(WIN_B_LAST), .DEPTH(WIN_DEPTH)) win_b_i (
      .clk(clk), .rst_n(rst_n), .pdn(ctrl_q[1]), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .hit(hit_b), .rdat(rdat_b), .store_flat(winb_store)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= 8'h00;
         for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= 8'h00;
         ctrl_q <= 2'b00;
      end else if (wr_en) begin
         if (unlocked && int'(cfg_off) < NUM_CFG) cfg_q[cfg_off[0 +: 1]] <= wdata;
         if (int'(gen_off) < NUM_GEN)             gen_q[gen_off[3:0] % NUM_GEN] <= wdata;
         if (addr == CTRL_ADDR)                   ctrl_q <= wdata[1:0];
      end
   end

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg_flat
      assign cfg_flat[g*8 +: 8] = cfg_q[g];
   end

   always_comb begin
      rd_val = 8'h00;
      if (addr == KEY_ADDR_FIRST)          rd_val = {7'b0, unlocked};
      else if (int'(cfg_off) < NUM_CFG)    rd_val = cfg_q[cfg_off[0 +: 1]];
      else if (addr == CTRL_ADDR)          rd_val = {6'b0, ctrl_q};
      else if (addr == STAT_ADDR)          rd_val = 8'(status);
      else if (addr == MASK_ADDR)          rd_val = 8'(mask);
      else if (int'(gen_off) < NUM_GEN)    rd_val = gen_q[gen_off[3:0] % NUM_GEN];
      else if (hit_a)                      rd_val = rdat_a;
      else if (hit_b)                      rd_val = rdat_b;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= 8'h00;
      else if (rd_en) rdata <= rd_val;
   end
endmodule

// File: rtl/lockreg_hub_chk.sv
module lockreg_hub_chk #(
   parameter int NUM_ALARMS = 4,
   parameter int NUM_CFG    = 2,
   parameter int WIN_DEPTH  = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cs,
   input logic                   wr,
   input logic                   rd,
   input logic [7:0]             addr,
   input logic [7:0]             wdata,
   input logic [7:0]             rdata,
   input logic [NUM_ALARMS-1:0]  alarm_in,
   input logic                   irq_n,
   input logic                   unlocked,
   input logic [NUM_ALARMS-1:0]  status,
   input logic [NUM_CFG*8-1:0]   cfg_flat,
   input logic [1:0]             ctrl_q,
   input logic [WIN_DEPTH*8-1:0] wina_store
);
   assert_open_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 8'h01 && wdata == 8'hFF &&
       $past(cs && wr && addr == 8'h00 && wdata == 8'h00)) |=> unlocked);

   assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(cfg_flat));

   assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_in != '0) |=> ((status & $past(alarm_in)) == $past(alarm_in)));

   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr && addr == 8'h08) |=> ((status & $past(status)) == $past(status)));

   assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> ($past(alarm_in) != '0 || $past(cs && wr)));

   assert_win_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[0] |=> $stable(wina_store));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && rd) |=> $stable(rdata));
endmodule

bind lockreg_hub lockreg_hub_chk #(
   .NUM_ALARMS(NUM_ALARMS), .NUM_CFG(NUM_CFG), .WIN_DEPTH(WIN_DEPTH)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
   .wdata(wdata), .rdata(rdata), .alarm_in(alarm_in), .irq_n(irq_n),
   .unlocked(unlocked), .status(status), .cfg_flat(cfg_flat),
   .ctrl_q(ctrl_q), .wina_store(wina_store)
);

// File: tb/lockreg_hub_tb_top.sv
module lockreg_hub_tb_top;
   localparam int NA = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [7:0]    addr = 8'h00, wdata = 8'h00;
   logic [7:0]    rdata;
   logic [NA-1:0] alarm_in = '0;
   logic          irq_n;
   int            checks = 0, fails = 0;

   always #4 clk = ~clk;

   lockreg_hub #(.NUM_ALARMS(NA)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .alarm_in(alarm_in), .irq_n(irq_n)
   );

   // entry: {requirement number, 1=write/0=read-and-compare, address, data or expected}
   localparam int NV = 24;
   localparam logic [20:0] VEC [NV] = '{
      {4'd1, 1'b0, 8'h00, 8'h00},  // R1 closed after reset
      {4'd1, 1'b0, 8'h09, 8'h0F},  // R1 mask reset value
      {4'd1, 1'b0, 8'h04, 8'h00},  // R1 control reset value
      {4'd3, 1'b1, 8'h02, 8'h55},  // R3 write while closed
      {4'd3, 1'b0, 8'h02, 8'h00},
      {4'd2, 1'b1, 8'h00, 8'h00},  // R2 open sequence
      {4'd2, 1'b1, 8'h01, 8'hFF},
      {4'd2, 1'b0, 8'h00, 8'h01},
      {4'd2, 1'b1, 8'h02, 8'h55},
      {4'd2, 1'b0, 8'h02, 8'h55},
      {4'd2, 1'b1, 8'h03, 8'hA7},
      {4'd2, 1'b0, 8'h03, 8'hA7},
      {4'd3, 1'b1, 8'h00, 8'hDE},  // R3 close sequence
      {4'd3, 1'b1, 8'h01, 8'hAD},
      {4'd3, 1'b0, 8'h00, 8'h00},
      {4'd3, 1'b1, 8'h02, 8'h11},
      {4'd3, 1'b0, 8'h02, 8'h55},
      {4'd3, 1'b1, 8'h03, 8'h00},
      {4'd3, 1'b0, 8'h03, 8'hA7},
      {4'd5, 1'b1, 8'h10, 8'h3C},  // R5 always-writable groups
      {4'd5, 1'b0, 8'h10, 8'h3C},
      {4'd5, 1'b1, 8'h13, 8'hC5},
      {4'd5, 1'b0, 8'h13, 8'hC5},
      {4'd5, 1'b1, 8'h09, 8'h0A}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); cs = 1'b0; wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
      @(negedge clk); cs = 1'b0; rd = 1'b0;
      check(req, rdata, exp);
   endtask

   task automatic pulse(input logic [NA-1:0] a);
      @(negedge clk); alarm_in = a;
      @(negedge clk); alarm_in = '0;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 rdata", rdata, 8'h00);
      check("R1 irq_n", {7'b0, irq_n}, 8'h01);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][16]) do_wr(VEC[i][15:8], VEC[i][7:0]);
         else rd_chk(VEC[i][15:8], VEC[i][7:0], $sformatf("R%0d step %0d", VEC[i][20:17], i));
      end
      rd_chk(8'h09, 8'h0A, "R5 mask readback");

      // R4: a write in the middle restarts the sequence
      do_wr(8'h00, 8'h00); do_wr(8'h10, 8'h77); do_wr(8'h01, 8'hFF);
      rd_chk(8'h00, 8'h00, "R4 broken open");
      do_wr(8'h00, 8'h00); rd_chk(8'h10, 8'h77, "R4 read between"); do_wr(8'h01, 8'hFF);
      rd_chk(8'h00, 8'h01, "R4 read keeps sequence");
      do_wr(8'h00, 8'hDE); do_wr(8'h01, 8'h00); do_wr(8'h01, 8'hAD);
      rd_chk(8'h00, 8'h01, "R4 broken close");
      do_wr(8'h00, 8'hDE); do_wr(8'h01, 8'hAD);
      rd_chk(8'h00, 8'h00, "R4 closed again");

      // R6 / R7: sticky status and masked interrupt (mask = 0x0A)
      check("R7 idle irq", {7'b0, irq_n}, 8'h01);
      pulse(4'b0001);
      check("R7 unmasked source", {7'b0, irq_n}, 8'h00);
      rd_chk(8'h08, 8'h01, "R6 status set");
      pulse(4'b0010);
      rd_chk(8'h08, 8'h03, "R6 masked bit still recorded");
      do_wr(8'h08, 8'h01);
      rd_chk(8'h08, 8'h02, "R6 write-one clear");
      check("R7 only masked pending", {7'b0, irq_n}, 8'h01);
      do_wr(8'h09, 8'h00);
      check("R7 mask removed", {7'b0, irq_n}, 8'h00);
      do_wr(8'h08, 8'h02);
      check("R7 cleared", {7'b0, irq_n}, 8'h01);
      @(negedge clk); cs = 1'b1; wr = 1'b1; addr = 8'h08; wdata = 8'h01; alarm_in = 4'b0001;
      @(negedge clk); cs = 1'b0; wr = 1'b0; alarm_in = '0;
      rd_chk(8'h08, 8'h01, "R6 set wins over clear");
      do_wr(8'h08, 8'h0F);
      check("R7 all clear", {7'b0, irq_n}, 8'h01);

      // R8 / R10: port A power-down
      do_wr(8'h20, 8'h5A); do_wr(8'h21, 8'hC3);
      rd_chk(8'h21, 8'hC3, "R8 window A live");
      do_wr(8'h04, 8'h01);
      do_wr(8'h20, 8'hFF);
      rd_chk(8'h20, 8'hC3, "R8 last value on read");
      rd_chk(8'h45, 8'hC3, "R8 top of window");
      do_wr(8'h60, 8'h99);
      rd_chk(8'h60, 8'h99, "R8 port B unaffected");
      do_wr(8'h04, 8'h00);
      rd_chk(8'h20, 8'h5A, "R10 contents kept A");
      rd_chk(8'h21, 8'hC3, "R10 contents kept A2");

      // R9 / R10: port B power-down
      rd_chk(8'h60, 8'h99, "R9 last read B");
      do_wr(8'h04, 8'h02);
      do_wr(8'h61, 8'h44);
      rd_chk(8'h61, 8'h99, "R9 last value on read");
      rd_chk(8'h85, 8'h99, "R9 top of window");
      rd_chk(8'h22, 8'h00, "R9 port A unaffected");
      do_wr(8'h04, 8'h00);
      rd_chk(8'h61, 8'h00, "R10 discarded write B");
      rd_chk(8'h60, 8'h99, "R10 contents kept B");

      // R11: rdata holds without a read strobe
      rd_chk(8'h13, 8'hC5, "R11 read");
      do_wr(8'h10, 8'h00);
      repeat (3) @(negedge clk);
      check("R11 hold", rdata, 8'hC5);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule